// File: doc/BRIEF.md
# Internal Data Space Address Mapper

This block sits between the operand-fetch logic of an 8-bit controller core and its on-chip data storage. Each cycle it accepts at most one access of one of four kinds (a plain byte address, a pointer-based byte access through a working register, a single-bit address, or a working-register number) and resolves it to a physical target. The target is either a 256-byte internal RAM or a 128-byte special-function-register file, together with a byte address and a bit index. The block holds both storage arrays, so it also performs the access itself. A single-bit write is completed as a read-modify-write inside one cycle.

The upper half of the byte address range has two meanings. A plain address of 0x80 or above reaches the register file. A pointer value of 0x80 or above reaches the upper half of the RAM. The working-register bank is taken from two bits of the status register in the register file, so software moves between banks by writing that register. A build parameter shrinks the RAM to 128 bytes. With that setting, pointer accesses above the populated range read as all ones and do not store anything.

Top module: `idm_mapper`

## Requirements
- R1: With `acc_kind`=0 (plain byte), addresses 0x00–0x7F target RAM at the same address (`tgt_sfr`=0), and addresses 0x80–0xFF target the register file (`tgt_sfr`=1) at the same address.
- R2: With `acc_kind`=1 (pointer), `acc_addr[0]` chooses R0 (0) or R1 (1) of the current bank as the pointer. The target is always RAM at the pointer value, including values 0x80–0xFF.
- R3: With `acc_kind`=3 (working register), `acc_addr[2:0]`=n targets RAM address bank*8+n. The bank is bits 4 (high) and 3 (low) of the status register at register-file address 0xD0, and it is visible on `bank`.
- R4: With `acc_kind`=2 (bit), a bit address below 0x80 targets RAM byte 0x20+addr[6:3] with bit index addr[2:0].
- R5: With `acc_kind`=2, a bit address of 0x80 or above targets the register-file byte {addr[7:3],000} with bit index addr[2:0].
- R6: A bit write sets the selected bit to `wr_bit` and leaves the other seven bits of the target byte unchanged.
- R7: One cycle after an access, `rd_valid` is 1. `rd_data` holds the target byte as it was before that access's write, and `rd_bit` holds its bit at `tgt_bit`. For byte kinds, `tgt_bit` is 0.
- R8: A write that changes the bank bits applies to the very next access.
- R9: With RAM_BYTES=128, pointer reads of 0x80–0xFF return 0xFF and pointer writes there are ignored.
- R10: After synchronous reset, `rd_valid` is 0, `rd_data` is 0x00, `bank` is 0, and all RAM and register bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 byte, 1 pointer, 2 bit, 3 working register |
| acc_write | input | 1 | The access writes |
| acc_addr | input | 8 | Byte address, bit address, register number or pointer select |
| wr_data | input | 8 | Byte to write |
| wr_bit | input | 1 | Bit value to write for bit accesses |
| tgt_sfr | output | 1 | Resolved target is the register file |
| tgt_addr | output | 8 | Resolved byte address |
| tgt_bit | output | 3 | Resolved bit index |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Target byte before the write |
| rd_bit | output | 1 | Selected bit of that byte |
| bank | output | 2 | Current working-register bank |

## Verification
Two functions share a cycle in this block. The first is a bit write, where the read of the old byte and the write of the merged byte happen in the same clock. The second is a bank change that has to steer a working-register access in the very next cycle. The bench issues back-to-back bit writes to the same RAM byte and to a register-file byte. It judges both the returned old byte and a later byte read. It also sets a bank bit through a bit write and a byte write, and in the next cycle issues a register access. It checks `tgt_addr` and the value read back at the expected bank slot.

// File: rtl/idm_pkg.sv
package idm_pkg;

    typedef enum logic [1:0] {
        K_DIRECT   = 2'd0,
        K_INDIRECT = 2'd1,
        K_BIT      = 2'd2,
        K_REG      = 2'd3
    } kind_e;

    typedef struct packed {
        logic       is_sfr;
        logic [7:0] addr;
        logic [2:0] bit_idx;
    } target_t;

    localparam int          SFR_BYTES  = 128;
    localparam logic [7:0]  STATUS_ADR = 8'hD0;
    localparam int          BANK_LSB   = 3;
    localparam logic [7:0]  BITRAM_BASE = 8'h20;

    // Resolve a bit address into byte target and bit index
    function automatic target_t bit_target(input logic [7:0] ba);
        target_t t;
        t.bit_idx = ba[2:0];
        if (ba[7]) begin
            t.is_sfr = 1'b1;
            t.addr   = {ba[7:3], 3'b000};
        end else begin
            t.is_sfr = 1'b0;
            t.addr   = BITRAM_BASE + {4'b0000, ba[6:3]};
        end
        return t;
    endfunction

    // Replace a single bit of a byte
    function automatic logic [7:0] merge_bit(input logic [7:0] old,
                                             input logic [2:0] idx,
                                             input logic       b);
        logic [7:0] m;
        m = 8'h01 << idx;
        return (old & ~m) | ({8{b}} & m);
    endfunction

endpackage

// File: rtl/idm_decode.sv
module idm_decode
    import idm_pkg::*;
(
    input  kind_e      kind,
    input  logic [7:0] addr,
    input  logic [1:0] bank,
    input  logic [7:0] ptr_val,
    output logic [7:0] ptr_addr,
    output target_t    tgt
);
    // Pointer register R0/R1 of the active bank
    assign ptr_addr = {3'b000, bank, 2'b00, addr[0]};

    always_comb begin
        tgt = '0;
        unique case (kind)
            K_DIRECT: begin
                tgt.is_sfr = addr[7];
                tgt.addr   = addr;
            end
            K_INDIRECT: begin
                tgt.is_sfr = 1'b0;
                tgt.addr   = ptr_val;
            end
            K_BIT: tgt = bit_target(addr);
            K_REG: begin
                tgt.is_sfr = 1'b0;
                tgt.addr   = {3'b000, bank, addr[2:0]};
            end
            default: tgt = '0;
        endcase
    end
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
    parameter int RAM_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] a_addr,
    output logic [7:0] a_data,
    input  logic [7:0] b_addr,
    output logic [7:0] b_data,
    input  logic       we,
    input  logic [7:0] wdata
);
    localparam int AW = $clog2(RAM_BYTES);

    logic [7:0] mem [RAM_BYTES];
    logic       a_in, b_in;

    generate
        if (RAM_BYTES >= 256) begin : g_full
            assign a_in = 1'b1;
            assign b_in = 1'b1;
        end else begin : g_part
            assign a_in = (a_addr[7:AW] == '0);
            assign b_in = (b_addr[7:AW] == '0);
        end
    endgenerate

    assign a_data = a_in ? mem[a_addr[AW-1:0]] : 8'hFF;
    assign b_data = b_in ? mem[b_addr[AW-1:0]] : 8'hFF;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_BYTES; i++) mem[i] <= 8'h00;
        end else if (we && b_in) begin
            mem[b_addr[AW-1:0]] <= wdata;
        end
    end
endmodule

// File: rtl/idm_sfr.sv
module idm_sfr
    import idm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [6:0] addr,
    output logic [7:0] rdata,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [1:0] bank
);
    logic [7:0] regs [SFR_BYTES];

    assign rdata = regs[addr];
    assign bank  = regs[STATUS_ADR[6:0]][BANK_LSB+1:BANK_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SFR_BYTES; i++) regs[i] <= 8'h00;
        end else if (we) begin
            regs[addr] <= wdata;
        end
    end

    // Bank only moves when the status byte is written
    AST_BANK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(we && addr == STATUS_ADR[6:0]) |=> $stable(bank)); // R8
endmodule

// File: rtl/idm_mapper.sv
module idm_mapper
    import idm_pkg::*;
#(
    parameter int RAM_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_valid,
    input  logic [1:0] acc_kind,
    input  logic       acc_write,
    input  logic [7:0] acc_addr,
    input  logic [7:0] wr_data,
    input  logic       wr_bit,
    output logic       tgt_sfr,
    output logic [7:0] tgt_addr,
    output logic [2:0] tgt_bit,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_bit,
    output logic [1:0] bank
);
    kind_e      kind;
    target_t    tgt;
    logic [7:0] ptr_addr, ptr_val;
    logic [7:0] ram_rd, sfr_rd, old_byte, new_byte;
    logic       ram_we, sfr_we;

    assign kind = kind_e'(acc_kind);

    idm_decode u_dec (
        .kind     (kind),
        .addr     (acc_addr),
        .bank     (bank),
        .ptr_val  (ptr_val),
        .ptr_addr (ptr_addr),
        .tgt      (tgt)
    );

    idm_ram #(.RAM_BYTES(RAM_BYTES)) u_ram (
        .clk    (clk),
        .rst    (rst),
        .a_addr (ptr_addr),
        .a_data (ptr_val),
        .b_addr (tgt.addr),
        .b_data (ram_rd),
        .we     (ram_we),
        .wdata  (new_byte)
    );

    idm_sfr u_sfr (
        .clk   (clk),
        .rst   (rst),
        .addr  (tgt.addr[6:0]),
        .rdata (sfr_rd),
        .we    (sfr_we),
        .wdata (new_byte),
        .bank  (bank)
    );

    assign old_byte = tgt.is_sfr ? sfr_rd : ram_rd;
    assign new_byte = (kind == K_BIT) ? merge_bit(old_byte, tgt.bit_idx, wr_bit)
                                      : wr_data;
    assign ram_we   = acc_valid && acc_write && !tgt.is_sfr;
    assign sfr_we   = acc_valid && acc_write &&  tgt.is_sfr;

    assign tgt_sfr  = tgt.is_sfr;
    assign tgt_addr = tgt.addr;
    assign tgt_bit  = tgt.bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
            rd_bit   <= 1'b0;
        end else begin
            rd_valid <= acc_valid;
            if (acc_valid) begin
                rd_data <= old_byte;
                rd_bit  <= old_byte[tgt.bit_idx];
            end
        end
    end

    AST_PTR_NEVER_SFR: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_kind == 2'd1 |-> !tgt_sfr); // R2
    AST_REG_WINDOW: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_kind == 2'd3 |-> !tgt_sfr && tgt_addr < 8'h20); // R3
    AST_BITRAM_RANGE: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_kind == 2'd2 && !acc_addr[7]
        |-> !tgt_sfr && tgt_addr[7:4] == 4'h2); // R4
    AST_BITSFR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_kind == 2'd2 && acc_addr[7]
        |-> tgt_sfr && tgt_addr[2:0] == 3'b000); // R5
    AST_BIT_ONLY_ONE: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_write && acc_kind == 2'd2
        |-> ((new_byte ^ old_byte) & ~(8'h01 << tgt_bit)) == 8'h00); // R6
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rd_valid); // R7
endmodule

// File: tb/idm_mapper_test.sv
module idm_mapper_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic [1:0] acc_kind  = 2'd0;
    logic       acc_write = 1'b0;
    logic [7:0] acc_addr  = 8'h00;
    logic [7:0] wr_data   = 8'h00;
    logic       wr_bit    = 1'b0;
    logic       tgt_sfr, rd_valid, rd_bit;
    logic [7:0] tgt_addr, rd_data;
    logic [2:0] tgt_bit;
    logic [1:0] bank;
    logic       s_tgt_sfr, s_rd_valid, s_rd_bit;
    logic [7:0] s_tgt_addr, s_rd_data;
    logic [2:0] s_tgt_bit;
    logic [1:0] s_bank;

    int n_cmp = 0;
    int n_bad = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    idm_mapper uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_write(acc_write), .acc_addr(acc_addr), .wr_data(wr_data),
        .wr_bit(wr_bit), .tgt_sfr(tgt_sfr), .tgt_addr(tgt_addr),
        .tgt_bit(tgt_bit), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_bit(rd_bit), .bank(bank)
    );

    idm_mapper #(.RAM_BYTES(128)) uut_small (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_write(acc_write), .acc_addr(acc_addr), .wr_data(wr_data),
        .wr_bit(wr_bit), .tgt_sfr(s_tgt_sfr), .tgt_addr(s_tgt_addr),
        .tgt_bit(s_tgt_bit), .rd_valid(s_rd_valid), .rd_data(s_rd_data),
        .rd_bit(s_rd_bit), .bank(s_bank)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Driver: present one access, check the resolved target, queue the result
    task automatic acc(input logic [1:0] k, input logic w, input logic [7:0] a,
                       input logic [7:0] wd, input logic wb,
                       input logic esfr, input logic [7:0] eaddr, input logic [2:0] ebit,
                       input logic [7:0] erd, input logic erb, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = k; acc_write = w;
        acc_addr = a; wr_data = wd; wr_bit = wb;
        exp_q.push_back({erd, erb});
        tag_q.push_back(tag);
        #1;
        chk({tag, " tgt_sfr"},  32'(tgt_sfr),  32'(esfr));
        chk({tag, " tgt_addr"}, 32'(tgt_addr), 32'(eaddr));
        chk({tag, " tgt_bit"},  32'(tgt_bit),  32'(ebit));
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Monitor: compare each result against the queue head
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected result", 32'(1), 32'(0));
            end else begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " rd_data"}, 32'(rd_data), 32'(e[8:1]));
                chk({t, " rd_bit"},  32'(rd_bit),  32'(e[0]));
            end
        end
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 rd_valid", 32'(rd_valid), 32'(0));
        chk("R10 rd_data",  32'(rd_data),  32'(0));
        chk("R10 bank",     32'(bank),     32'(0));

        // R1 plain byte accesses on both halves
        acc(2'd0, 1, 8'h35, 8'hA7, 0, 0, 8'h35, 0, 8'h00, 0, "R1 wr ram 0x35");
        acc(2'd0, 0, 8'h35, 8'h00, 0, 0, 8'h35, 0, 8'hA7, 1, "R1 R7 rd ram 0x35");
        acc(2'd0, 1, 8'h90, 8'h3C, 0, 1, 8'h90, 0, 8'h00, 0, "R1 wr sfr 0x90");
        acc(2'd0, 0, 8'h90, 8'h00, 0, 1, 8'h90, 0, 8'h3C, 0, "R1 rd sfr 0x90");
        // R4 R6 bit writes to RAM byte 0x21, back to back
        acc(2'd2, 1, 8'h0B, 8'h00, 1, 0, 8'h21, 3, 8'h00, 0, "R4 bitset 0x0B");
        acc(2'd2, 1, 8'h0E, 8'h00, 1, 0, 8'h21, 6, 8'h08, 0, "R6 bitset 0x0E");
        acc(2'd0, 0, 8'h21, 8'h00, 0, 0, 8'h21, 0, 8'h48, 0, "R6 rd 0x21");
        acc(2'd2, 1, 8'h0B, 8'h00, 0, 0, 8'h21, 3, 8'h48, 1, "R6 bitclr 0x0B");
        acc(2'd0, 0, 8'h21, 8'h00, 0, 0, 8'h21, 0, 8'h40, 0, "R6 rd 0x21 after clr");
        // R5 bit write into register file
        acc(2'd2, 1, 8'h92, 8'h00, 0, 1, 8'h90, 2, 8'h3C, 1, "R5 bitclr 0x92");
        acc(2'd0, 0, 8'h90, 8'h00, 0, 1, 8'h90, 0, 8'h38, 0, "R5 rd sfr 0x90");
        // R8 bank bit set by bit write, used by the very next access
        acc(2'd2, 1, 8'hD3, 8'h00, 1, 1, 8'hD0, 3, 8'h00, 0, "R8 set bank bit");
        acc(2'd3, 1, 8'h02, 8'h77, 0, 0, 8'h0A, 0, 8'h00, 0, "R3 R8 wr R2 bank1");
        chk("R8 bank after bit write", 32'(bank), 32'(1));
        acc(2'd0, 0, 8'h0A, 8'h00, 0, 0, 8'h0A, 0, 8'h77, 1, "R3 rd 0x0A");
        // bank 3 via byte write to status register
        acc(2'd0, 1, 8'hD0, 8'h18, 0, 1, 8'hD0, 0, 8'h08, 0, "R8 wr status");
        acc(2'd3, 1, 8'h01, 8'hC0, 0, 0, 8'h19, 0, 8'h00, 0, "R3 R8 wr R1 bank3");
        chk("R3 bank 3", 32'(bank), 32'(3));
        // R2 pointer through R1 into the upper RAM half
        acc(2'd1, 1, 8'h01, 8'h5A, 0, 0, 8'hC0, 0, 8'h00, 0, "R2 ptr wr 0xC0");
        acc(2'd1, 0, 8'h01, 8'h00, 0, 0, 8'hC0, 0, 8'h5A, 0, "R2 ptr rd 0xC0");
        idle();
        #1;
        chk("R9 small ptr rd high", 32'(s_rd_data), 32'(8'hFF));
        chk("R9 small rd_valid",    32'(s_rd_valid), 32'(1));
        acc(2'd0, 0, 8'hC0, 8'h00, 0, 1, 8'hC0, 0, 8'h00, 0, "R1 R2 plain 0xC0 is sfr");
        // R2 pointer through R0 into the lower half
        acc(2'd3, 1, 8'h00, 8'h35, 0, 0, 8'h18, 0, 8'h00, 0, "R3 wr R0 bank3");
        acc(2'd1, 0, 8'h00, 8'h00, 0, 0, 8'h35, 0, 8'hA7, 1, "R2 ptr rd via R0");
        acc(2'd3, 0, 8'h01, 8'h00, 0, 0, 8'h19, 0, 8'hC0, 0, "R3 rd R1 bank3");
        idle();
        idle();
        chk("R7 all results seen", 32'(exp_q.size()), 32'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule